// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a 12-bit successive-approximation converter with a byte-wide processor port. A host starts a conversion by pulling chip-select and write low together. The controller then runs an autozero interval of a fixed number of clocks. After that it does a binary search from the top bit down to bit 0. In each search step it presents a trial code to an external DAC and samples a single comparator line that tells whether the analog input is at or above that trial level.

The finished code is held in a result register. The host reads it over an 8-bit bus as two bytes, and the byte-select input chooses which byte. The low byte carries result bits 7..0. The high byte carries an in-data busy flag, three zero bits and result bits 11..8. The host also has a dedicated active-low busy pin. The bus value and its enable are driven as separate outputs, and a pad ring combines them into the tri-state drivers.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion starts on the clock edge that first samples chip-select and write both low while the controller is idle. From the next cycle `busy_n` is low.
- R2: The first AZ_CYCLES cycles of every conversion are autozero. During them `az_en` is 1 and `dac_code` is 0.
- R3: `busy_n` stays low for exactly AZ_CYCLES+12 cycles per conversion and is high at all other times.
- R4: The search decides one bit per clock, from bit 11 down to bit 0. A bit is kept when `cmp_in` is 1 (input at or above the trial code). With an ideal comparator the result equals the input code for every value 0..4095.
- R5: `bus_en` is 1 only while `cs_n` and `rd_n` are both low.
- R6: With `byte_sel` = 0, `bus_q[7:0]` equals result bits 7..0, and result bit 0 is on `bus_q[0]`.
- R7: With `byte_sel` = 1, `bus_q[7]` is 1 during a conversion and 0 otherwise, `bus_q[6:4]` are 0, and `bus_q[3:0]` equal result bits 11..8.
- R8: The two bytes can be read in either order. If `byte_sel` changes during a read, the bus byte follows it in the same cycle.
- R9: The result register changes only at the end of a conversion, so a read during a conversion returns the previous result.
- R10: A new chip-select/write strobe arriving during a conversion is ignored. It neither lengthens nor restarts the conversion in progress.
- R11: After reset the result is 0, `busy_n` is high, the in-data busy flag is 0 and `bus_en` is 0 while no read is active.
- R12: The first search cycle after autozero presents 0x800 (only bit 11 set) on `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; with cs_n starts a conversion |
| rd_n | input | 1 | Read strobe, active low; with cs_n enables the bus |
| byte_sel | input | 1 | 0 selects the low result byte, 1 the status/high byte |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | 12 | Trial code for the external DAC |
| az_en | output | 1 | High during the autozero interval |
| busy_n | output | 1 | Low while a conversion is running |
| bus_q | output | 8 | Byte value for the data pads |
| bus_en | output | 1 | Output enable for the data pads |

## Verification
An ideal comparator model in the bench answers against an input code, and that code is swept over all 4096 values. This shows that every bit decision uses the at-or-above rule, because an off-by-one compare or a wrong bit order would corrupt some codes. A conversion that starts while an older result is held shows that the result is latched only at the end. A second strobe sent during that conversion shows that a strobe received while busy is ignored. Toggling byte-select during one read, and reading the bytes in both orders, shows that the mux follows byte-select live. The flag and zero fields are checked in both the busy and idle states.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_AZ    = 2'd1,
        ST_TRIAL = 2'd2
    } sar_state_e;

    // One-hot mask for the bit under trial
    function automatic logic [15:0] bit_mask(input logic [3:0] idx);
        return 16'd1 << idx;
    endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_BITS  = 12,
    parameter int AZ_CYCLES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_n,
    input  logic                        wr_n,
    output sar_state_e                  state_o,
    output logic [$clog2(RES_BITS)-1:0] bit_idx_o,
    output logic                        finish_o
);
    localparam int IDX_W = $clog2(RES_BITS);
    localparam int AZ_W  = $clog2(AZ_CYCLES + 1);

    sar_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [AZ_W-1:0]  az_cnt;
    logic             strobe, strobe_q;

    assign strobe = ~cs_n & ~wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            az_cnt   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
            unique case (state)
                ST_IDLE: begin
                    if (strobe && !strobe_q) begin
                        state  <= ST_AZ;
                        az_cnt <= '0;
                    end
                end
                ST_AZ: begin
                    if (az_cnt == AZ_W'(AZ_CYCLES - 1)) begin
                        state <= ST_TRIAL;
                        idx   <= IDX_W'(RES_BITS - 1);
                    end else begin
                        az_cnt <= az_cnt + 1'b1;
                    end
                end
                ST_TRIAL: begin
                    if (idx == '0) state <= ST_IDLE;
                    else           idx   <= idx - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign state_o   = state;
    assign bit_idx_o = idx;
    assign finish_o  = (state == ST_TRIAL) && (idx == '0);

endmodule

// File: rtl/sar_search.sv
module sar_search
    import sar_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  sar_state_e                  state,
    input  logic [$clog2(RES_BITS)-1:0] bit_idx,
    input  logic                        finish,
    input  logic                        cmp_in,
    output logic [RES_BITS-1:0]         dac_code,
    output logic [RES_BITS-1:0]         result
);
    logic [RES_BITS-1:0] work, mask, next_work;

    assign mask      = RES_BITS'(bit_mask(4'(bit_idx)));
    assign next_work = cmp_in ? (work | mask) : work;

    always_ff @(posedge clk) begin
        if (rst) begin
            work   <= '0;
            result <= '0;
        end else begin
            if (state == ST_AZ)    work <= '0;
            if (state == ST_TRIAL) work <= next_work;
            if (finish)            result <= next_work;
        end
    end

    assign dac_code = (state == ST_TRIAL) ? (work | mask) : '0;

endmodule

// File: rtl/sar_rdmux.sv
module sar_rdmux
    import sar_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                cs_n,
    input  logic                rd_n,
    input  logic                byte_sel,
    input  logic                busy_flag,
    input  logic [RES_BITS-1:0] result,
    output logic [BUS_W-1:0]    bus_q,
    output logic                bus_en
);
    localparam int HI_W  = RES_BITS - BUS_W;
    localparam int PAD_W = BUS_W - 1 - HI_W;

    logic [BUS_W-1:0] lo_byte, hi_byte;

    assign lo_byte = result[BUS_W-1:0];
    assign hi_byte = {busy_flag, {PAD_W{1'b0}}, result[RES_BITS-1:BUS_W]};
    assign bus_q   = byte_sel ? hi_byte : lo_byte;
    assign bus_en  = ~cs_n & ~rd_n;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int RES_BITS  = 12,
    parameter int AZ_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                wr_n,
    input  logic                rd_n,
    input  logic                byte_sel,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic                az_en,
    output logic                busy_n,
    output logic [7:0]          bus_q,
    output logic                bus_en
);
    localparam int IDX_W = $clog2(RES_BITS);

    sar_state_e          state;
    logic [IDX_W-1:0]    bit_idx;
    logic                finish;
    logic [RES_BITS-1:0] result;
    logic                busy;

    sar_seq #(.RES_BITS(RES_BITS), .AZ_CYCLES(AZ_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n),
        .state_o(state), .bit_idx_o(bit_idx), .finish_o(finish)
    );

    sar_search #(.RES_BITS(RES_BITS)) u_search (
        .clk(clk), .rst(rst), .state(state), .bit_idx(bit_idx),
        .finish(finish), .cmp_in(cmp_in),
        .dac_code(dac_code), .result(result)
    );

    assign busy   = (state != ST_IDLE);
    assign busy_n = ~busy;
    assign az_en  = (state == ST_AZ);

    sar_rdmux #(.RES_BITS(RES_BITS)) u_rdmux (
        .cs_n(cs_n), .rd_n(rd_n), .byte_sel(byte_sel),
        .busy_flag(busy), .result(result),
        .bus_q(bus_q), .bus_en(bus_en)
    );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int RES_BITS  = 12,
    parameter int AZ_CYCLES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                cs_n,
    input logic                rd_n,
    input logic                byte_sel,
    input logic                busy_n,
    input logic                az_en,
    input logic [RES_BITS-1:0] dac_code,
    input logic                bus_en,
    input logic [7:0]          bus_q,
    input logic [RES_BITS-1:0] result
);
    // R2
    az_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> az_en);

    // R2
    az_dac_chk: assert property (@(posedge clk) disable iff (rst)
        az_en |-> (dac_code == '0 && !busy_n));

    // R12
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(az_en) && !busy_n) |->
            (dac_code[RES_BITS-1] && dac_code[RES_BITS-2:0] == '0));

    // R5
    bus_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> !bus_en);

    // R7
    hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && byte_sel) |->
            (bus_q[6:RES_BITS-8] == '0 && bus_q[7] == !busy_n));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && !$past(busy_n)) |-> $stable(result));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_BITS(RES_BITS), .AZ_CYCLES(AZ_CYCLES)) i_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .byte_sel(byte_sel),
    .busy_n(busy_n), .az_en(az_en), .dac_code(dac_code),
    .bus_en(bus_en), .bus_q(bus_q), .result(result)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
    localparam int AZ = 2;
    localparam int CONV_LEN = AZ + 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, byte_sel = 1'b0;
    logic        cmp_in;
    logic [11:0] dac_code;
    logic        az_en, busy_n, bus_en;
    logic [7:0]  bus_q;
    logic [11:0] vin = '0;

    int total = 0;
    int bad   = 0;

    sar_adc_ctrl #(.RES_BITS(12), .AZ_CYCLES(AZ)) i_sar_adc_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .byte_sel(byte_sel), .cmp_in(cmp_in), .dac_code(dac_code),
        .az_en(az_en), .busy_n(busy_n), .bus_q(bus_q), .bus_en(bus_en)
    );

    always #10 clk = ~clk;

    // ideal comparator: high when input at or above trial level
    assign cmp_in = (vin >= dac_code);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd_byte(input logic sel, output logic [7:0] b);
        cs_n = 1'b0; rd_n = 1'b0; byte_sel = sel;
        #1 b = bus_q;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    // starts at a negedge, returns at a negedge with busy_n high
    task automatic do_conv(input logic [11:0] v, output int ncyc);
        vin = v;
        cs_n = 1'b0; wr_n = 1'b0;
        ncyc = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == AZ) begin cs_n = 1'b1; wr_n = 1'b1; end
            if (!busy_n) ncyc++;
            else break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] lo, hi;
        int n;
        logic [11:0] a_val, b_val;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 busy_n", busy_n, 1);
        chk("R11 bus_en idle", bus_en, 0);
        rd_byte(1'b0, lo);
        rd_byte(1'b1, hi);
        chk("R11 result low", lo, 0);
        chk("R11 flag/high", hi, 0);

        // R5 bus enable gating
        cs_n = 1'b0; rd_n = 1'b1; #1 chk("R5 cs only", bus_en, 0);
        cs_n = 1'b1; rd_n = 1'b0; #1 chk("R5 rd only", bus_en, 0);
        cs_n = 1'b0; rd_n = 1'b0; #1 chk("R5 both", bus_en, 1);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);

        // R1 R2 R12 first conversion, step by step
        vin = 12'hA5C;
        cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        chk("R1 busy_n after start", busy_n, 0);
        for (int i = 0; i < AZ; i++) begin
            if (i > 0) @(negedge clk);
            chk("R2 az_en", az_en, 1);
            chk("R2 dac during autozero", dac_code, 0);
        end
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        chk("R12 first trial code", dac_code, 12'h800);
        chk("R2 az_en off", az_en, 0);
        while (!busy_n) @(negedge clk);
        rd_byte(1'b0, lo);
        rd_byte(1'b1, hi);
        chk("R4 first result", {hi[3:0], lo}, 12'hA5C);

        // R9 R10 R7 R8: read during conversion, extra strobe ignored
        a_val = 12'h3C7;
        b_val = 12'hC18;
        do_conv(a_val, n);
        chk("R3 length A", n, CONV_LEN);
        vin = b_val;
        cs_n = 1'b0; wr_n = 1'b0;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 1) begin cs_n = 1'b1; wr_n = 1'b1; end
            if (i == 4) begin
                cs_n = 1'b0; rd_n = 1'b0; byte_sel = 1'b0;
                #1 chk("R9 low byte holds old", bus_q, a_val[7:0]);
                byte_sel = 1'b1;
                #1 chk("R8 R7 live switch to high, flag set", bus_q, {1'b1, 3'b000, a_val[11:8]});
                byte_sel = 1'b0;
                #1 chk("R8 live switch back", bus_q, a_val[7:0]);
                cs_n = 1'b1; rd_n = 1'b1;
            end
            if (i == 5) begin cs_n = 1'b0; wr_n = 1'b0; end
            if (i == 6) begin cs_n = 1'b1; wr_n = 1'b1; end
            if (!busy_n) n++;
            else break;
        end
        chk("R10 length with stray strobe", n, CONV_LEN);
        repeat (3) @(negedge clk);
        chk("R10 no restart", busy_n, 1);
        rd_byte(1'b1, hi);
        rd_byte(1'b0, lo);
        chk("R10 R8 result B, high first", {hi[3:0], lo}, b_val);
        chk("R7 flag clear when idle", hi[7:4], 0);

        // R4 R6 R3 exhaustive sweep
        for (int v = 0; v < 4096; v++) begin
            do_conv(12'(v), n);
            chk("R3 busy length", n, CONV_LEN);
            rd_byte(1'b0, lo);
            rd_byte(1'b1, hi);
            chk("R4 R6 conversion result", {hi[3:0], lo}, v);
            if (v == 4095) chk("R7 pad and flag", hi[7:4], 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule